// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between an external microcontroller bus and the register file of a peripheral controller. It accepts two strobe conventions on the same pins, selected by a static style input. In the 68xx convention, one pin is an active-low data strobe and the other is a read/write direction. In the 80xx convention, the pins are separate active-low read and write strobes. Every access is qualified by an active-low chip select. Each bus pin is brought into the system clock through a synchronizer chain. Every completed strobe assertion is turned into exactly one single-cycle read or write pulse toward the register file, together with a 3-bit register index and 8-bit write data.

The register index comes from one of two places. It can come from three dedicated address pins. It can also come from the low three data lines, which are captured by an address latch enable that shares the top address pin. The choice is strapped: address pin 0 is sampled while reset is held, and a low level selects multiplexed addressing. During reads the block supplies the register file's data to the pad ring on a separate output, with an enable that stays low at all other times. It also turns masked interrupt requests into an active-low interrupt pin, and it provides a synchronized copy of the hardware reset to the core.

Top module: `hbus_front`

## Requirements
- R1: While `hw_rst_n` is low, `core_rst_n` is 0, `irq_n` is 1, `bus_d_oe` is 0 and no strobes are issued. After `hw_rst_n` rises, `core_rst_n` is still 0 after the first rising clock edge and is 1 after the second.
- R2: If `addr_pin[0]` is 1 while reset is held, the block runs in direct mode. In direct mode the register index of an access is `addr_pin[2:0]`, with bit 0 as the least significant bit.
- R3: If `addr_pin[0]` is 0 while reset is held, the block runs in multiplexed mode. In this mode `addr_pin[2]` acts as the address latch enable, and its falling edge captures `bus_d_in[2:0]` as the register index. That index is kept for later accesses until the next falling edge. `addr_pin[1]` has no effect.
- R4: With `style_68` = 1, a low `rd_ds_n` is the data strobe. While the strobe is low, `wr_dir_n` = 1 means a read and `wr_dir_n` = 0 means a write.
- R5: With `style_68` = 0, a low `rd_ds_n` means a read and a low `wr_dir_n` means a write.
- R6: While `cs_n` is high, no read or write pulse is issued and `bus_d_oe` stays 0, whatever the strobes do.
- R7: Each write assertion under chip select gives exactly one single-cycle `reg_wr_stb` pulse. The pulse carries the index and all eight `bus_d_in` bits that were present during the strobe.
- R8: Each read assertion under chip select gives exactly one single-cycle `reg_rd_stb` pulse.
- R9: While a selected read is held, `bus_d_oe` is 1 and `bus_d_out` equals `reg_rdata` for the accessed index. After the read or the chip select is removed, `bus_d_oe` returns to 0.
- R10: `irq_n` is 0 one clock after any bit of `irq_req & irq_en` is set, and 1 one clock after none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| style_68 | input | 1 | Static bus convention: 1 = strobe+direction, 0 = separate read/write |
| addr_pin | input | 3 | Address pins; bit 0 is the mux strap during reset, bit 2 is the latch enable in multiplexed mode |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe (80xx) or data strobe (68xx), active low |
| wr_dir_n | input | 1 | Write strobe (80xx) or direction, 1 = read (68xx) |
| bus_d_in | input | 8 | Data lines from the pad, carrying the address on bits 2:0 in multiplexed mode |
| bus_d_out | output | 8 | Read data toward the pad |
| bus_d_oe | output | 1 | Pad output enable |
| irq_n | output | 1 | Active-low interrupt |
| irq_req | input | 4 | Interrupt requests from the core |
| irq_en | input | 4 | Interrupt enables |
| core_rst_n | output | 1 | Reset toward the core: asserts asynchronously, released in sync with the clock |
| reg_wr_stb | output | 1 | Register-file write pulse |
| reg_rd_stb | output | 1 | Register-file read pulse |
| reg_idx | output | 3 | Register index |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register-file read data for `reg_idx` |

## Verification
A change in the interrupt requests can arrive in the same clock as a write or read pulse. A latch-enable fall can also come just before a strobe, so that the new index must already be in use for that strobe. The bench changes `irq_req`/`irq_en` at random in the very cycle the access strobe falls, and then checks the pulse count, index, data and `irq_n` against independent models before the next access. Directed accesses without a new latch event confirm that the held multiplexed index is not disturbed by interrupt traffic or by the unused address pin.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic {
    STYLE_SEP_RW  = 1'b0,
    STYLE_DS_DIR  = 1'b1
  } bus_style_e;

  localparam int HB_SYNC_STAGES = 2;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= RST_VAL;
      else        chain_q[g] <= chain_d[g];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbus_rst_sync.sv
module hbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] rst_d;

  always_comb begin
    rst_d = {rst_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= rst_d;
  end

  assign rst_n_out = rst_q[STAGES-1];

  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_out) |-> $past(arst_n));
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mux_en,
  input  logic             ale_s,
  input  logic [IDX_W-1:0] lo_data_s,
  output logic [IDX_W-1:0] idx_q
);
  logic             ale_prev_q, ale_prev_d;
  logic [IDX_W-1:0] idx_d;
  logic             ale_fall;

  always_comb begin
    ale_fall   = mux_en & ale_prev_q & ~ale_s;
    ale_prev_d = ale_s;
    idx_d      = idx_q;
    if (ale_fall) idx_d = lo_data_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_prev_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      ale_prev_q <= ale_prev_d;
      idx_q      <= idx_d;
    end
  end

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_prev_q && !ale_s) |=> $stable(idx_q));
endmodule

// File: rtl/hbus_xfer.sv
module hbus_xfer
  import hbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_style_e        style,
  input  logic              cs_s_n,
  input  logic              rd_ds_s_n,
  input  logic              wr_dir_s_n,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] data_s,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              oe_q
);
  logic              rd_qual, wr_qual;
  logic              rd_prev_q, wr_prev_q;
  logic              rd_start, wr_start;
  logic              wr_stb_d, rd_stb_d, oe_d;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] wdata_d, dout_d;

  always_comb begin
    if (style == STYLE_DS_DIR) begin
      rd_qual = ~cs_s_n & ~rd_ds_s_n &  wr_dir_s_n;
      wr_qual = ~cs_s_n & ~rd_ds_s_n & ~wr_dir_s_n;
    end else begin
      rd_qual = ~cs_s_n & ~rd_ds_s_n;
      wr_qual = ~cs_s_n & ~wr_dir_s_n;
    end
    rd_start = rd_qual & ~rd_prev_q;
    wr_start = wr_qual & ~wr_prev_q;
    rd_stb_d = rd_start;
    wr_stb_d = wr_start;
    oe_d     = rd_qual;
    idx_d    = idx_q;
    if (rd_qual | wr_qual) idx_d = idx_in;
    wdata_d  = wdata_q;
    if (wr_start) wdata_d = data_s;
    dout_d   = dout_q;
    if (rd_qual) dout_d = reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      oe_q      <= 1'b0;
      idx_q     <= '0;
      wdata_q   <= '0;
      dout_q    <= '0;
    end else begin
      rd_prev_q <= rd_qual;
      wr_prev_q <= wr_qual;
      rd_stb    <= rd_stb_d;
      wr_stb    <= wr_stb_d;
      oe_q      <= oe_d;
      idx_q     <= idx_d;
      wdata_q   <= wdata_d;
      dout_q    <= dout_d;
    end
  end

  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  // R6
  cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s_n |=> (!wr_stb && !rd_stb && !oe_q));

  // R9
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ds_s_n && !oe_q) |=> !oe_q);
endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int IRQ_N  = 4,
  parameter int STAGES = HB_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              style_68,
  input  logic [IDX_W-1:0]  addr_pin,
  input  logic              cs_n,
  input  logic              rd_ds_n,
  input  logic              wr_dir_n,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic              irq_n,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic [IRQ_N-1:0]  irq_en,
  output logic              core_rst_n,
  output logic              reg_wr_stb,
  output logic              reg_rd_stb,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic [IDX_W-1:0]  addr_s;
  logic [DATA_W-1:0] data_s;
  logic [IDX_W-1:0]  latched_idx;
  logic [IDX_W-1:0]  idx_sel;
  logic              mux_mode_q, mux_mode_d;
  logic              irq_n_d;
  bus_style_e        style;

  hbus_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk(clk), .arst_n(hw_rst_n), .rst_n_out(core_rst_n));

  hbus_sync #(.W(CTRL_W), .STAGES(STAGES), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
    .clk(clk), .rst_n(core_rst_n), .d({cs_n, rd_ds_n, wr_dir_n}), .q(ctrl_s));

  hbus_sync #(.W(IDX_W), .STAGES(STAGES), .RST_VAL('0)) u_addr_sync (
    .clk(clk), .rst_n(core_rst_n), .d(addr_pin), .q(addr_s));

  hbus_sync #(.W(DATA_W), .STAGES(STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst_n(core_rst_n), .d(bus_d_in), .q(data_s));

  // Addressing strap: sampled only while the core is held in reset.
  always_comb begin
    mux_mode_d = mux_mode_q;
    if (!core_rst_n) mux_mode_d = ~addr_pin[0];
  end

  always_ff @(posedge clk) begin
    mux_mode_q <= mux_mode_d;
  end

  hbus_addr_latch #(.IDX_W(IDX_W)) u_alat (
    .clk(clk), .rst_n(core_rst_n), .mux_en(mux_mode_q),
    .ale_s(addr_s[IDX_W-1]), .lo_data_s(data_s[IDX_W-1:0]), .idx_q(latched_idx));

  always_comb begin
    idx_sel = mux_mode_q ? latched_idx : addr_s;
    style   = style_68 ? STYLE_DS_DIR : STYLE_SEP_RW;
  end

  hbus_xfer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_xfer (
    .clk(clk), .rst_n(core_rst_n), .style(style),
    .cs_s_n(ctrl_s[2]), .rd_ds_s_n(ctrl_s[1]), .wr_dir_s_n(ctrl_s[0]),
    .idx_in(idx_sel), .data_s(data_s), .reg_rdata(reg_rdata),
    .wr_stb(reg_wr_stb), .rd_stb(reg_rd_stb), .idx_q(reg_idx),
    .wdata_q(reg_wdata), .dout_q(bus_d_out), .oe_q(bus_d_oe));

  always_comb begin
    irq_n_d = ~(|(irq_req & irq_en));
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) irq_n <= 1'b1;
    else             irq_n <= irq_n_d;
  end

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (|(irq_req & irq_en)) |=> !irq_n);

  // R6
  no_strobe_pair_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(reg_wr_stb && reg_rd_stb));
endmodule

// File: tb/hbus_front_test.sv
`timescale 1ns/1ps
module hbus_front_test;
  logic       clk = 1'b0;
  logic       hw_rst_n, style_68, cs_n, rd_ds_n, wr_dir_n;
  logic [2:0] addr_pin;
  logic [7:0] bus_d_in, bus_d_out, reg_wdata, reg_rdata;
  logic       bus_d_oe, irq_n, core_rst_n, reg_wr_stb, reg_rd_stb;
  logic [3:0] irq_req, irq_en;
  logic [2:0] reg_idx;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [2:0] last_idx;
  logic [7:0] last_wdata;
  bit         mux_cfg;
  logic [2:0] exp_latch;

  always #10 clk = ~clk;

  hbus_front uut (
    .clk(clk), .hw_rst_n(hw_rst_n), .style_68(style_68), .addr_pin(addr_pin),
    .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_dir_n(wr_dir_n), .bus_d_in(bus_d_in),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .irq_n(irq_n),
    .irq_req(irq_req), .irq_en(irq_en), .core_rst_n(core_rst_n),
    .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [7:0] rd_model(input logic [2:0] i);
    return 8'h3C ^ {i, i[1:0], i};
  endfunction

  function automatic logic exp_irq_n(input logic [3:0] rq, input logic [3:0] en);
    return ~(|(rq & en));
  endfunction

  assign reg_rdata = rd_model(reg_idx);

  always @(negedge clk) begin
    if (reg_wr_stb) begin
      wr_cnt     <= wr_cnt + 1;
      last_idx   <= reg_idx;
      last_wdata <= reg_wdata;
    end
    if (reg_rd_stb) rd_cnt <= rd_cnt + 1;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset(input bit mux);
    hw_rst_n = 1'b0;
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_dir_n = 1'b1;
    addr_pin = mux ? 3'b000 : 3'b001;
    mux_cfg = mux;
    exp_latch = 3'd0;
    cyc(3);
    // R1 reset state
    chk(core_rst_n == 1'b0, "R1 core_rst_n low", {31'd0, core_rst_n}, 0);
    chk(irq_n == 1'b1 && bus_d_oe == 1'b0 && !reg_wr_stb && !reg_rd_stb,
        "R1 idle outputs", {28'd0, irq_n, bus_d_oe, reg_wr_stb, reg_rd_stb}, 32'h8);
    hw_rst_n = 1'b1;
    cyc(1);
    chk(core_rst_n == 1'b0, "R1 release edge1", {31'd0, core_rst_n}, 0);
    cyc(1);
    chk(core_rst_n == 1'b1, "R1 release edge2", {31'd0, core_rst_n}, 1);
    cyc(2);
  endtask

  task automatic irq_set_rand;
    irq_req = 4'($urandom);
    irq_en  = 4'($urandom);
  endtask

  task automatic xact(input bit s68, input bit do_rd, input bit sel,
                      input logic [2:0] idx, input logic [7:0] dat, input bit relatch);
    int w0, r0;
    logic [2:0] eff;
    bit exp_w, exp_r;
    w0 = wr_cnt; r0 = rd_cnt;
    style_68 = s68;
    if (mux_cfg) begin
      if (relatch) begin
        bus_d_in = {5'd0, idx};
        addr_pin = {1'b0, 1'($urandom), 1'b0};
        cyc(1);
        addr_pin[2] = 1'b1;
        cyc(3);
        addr_pin[2] = 1'b0;
        cyc(4);
        exp_latch = idx;
      end
      addr_pin[1] = 1'($urandom);   // unused pin in multiplexed mode (R3)
      eff = exp_latch;
    end else begin
      addr_pin = idx;
      eff = idx;
    end
    bus_d_in = dat;
    cs_n = ~sel;
    if (s68) wr_dir_n = do_rd;
    cyc(1);
    if (s68)        rd_ds_n  = 1'b0;
    else if (do_rd) rd_ds_n  = 1'b0;
    else            wr_dir_n = 1'b0;
    irq_set_rand();                 // interrupt change in the same cycle as the strobe
    cyc(8);
    exp_w = sel && !do_rd;
    exp_r = sel && do_rd;
    chk(irq_n == exp_irq_n(irq_req, irq_en), "R10 irq during access",
        {31'd0, irq_n}, {31'd0, exp_irq_n(irq_req, irq_en)});
    chk(bus_d_oe == exp_r, sel ? "R9 oe during access" : "R6 oe deselected",
        {31'd0, bus_d_oe}, {31'd0, exp_r});
    if (exp_r)
      chk(bus_d_out == rd_model(eff), mux_cfg ? "R9 R3 read data" : "R9 R2 read data",
          {24'd0, bus_d_out}, {24'd0, rd_model(eff)});
    rd_ds_n = 1'b1; wr_dir_n = 1'b1; cs_n = 1'b1;
    cyc(5);
    chk(bus_d_oe == 1'b0, "R9 oe released", {31'd0, bus_d_oe}, 0);
    chk(wr_cnt - w0 == int'(exp_w), s68 ? "R4 R7 write pulses" : "R5 R7 write pulses",
        wr_cnt - w0, {31'd0, exp_w});
    chk(rd_cnt - r0 == int'(exp_r), s68 ? "R4 R8 read pulses" : "R5 R8 read pulses",
        rd_cnt - r0, {31'd0, exp_r});
    if (exp_w) begin
      chk(last_idx == eff, mux_cfg ? "R3 write index" : "R2 write index",
          {29'd0, last_idx}, {29'd0, eff});
      chk(last_wdata == dat, "R7 write data", {24'd0, last_wdata}, {24'd0, dat});
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    style_68 = 1'b0;
    bus_d_in = 8'h00;
    irq_req = 4'h0; irq_en = 4'h0;
    do_reset(1'b0);

    // R10 directed: single source enabled, then masked
    irq_req = 4'b0100; irq_en = 4'b0100; cyc(2);
    chk(irq_n == 1'b0, "R10 enabled request", {31'd0, irq_n}, 0);
    irq_en = 4'b1011; cyc(2);
    chk(irq_n == 1'b1, "R10 masked request", {31'd0, irq_n}, 1);

    // R2 R4 R5 directed, boundary indices
    xact(1'b0, 1'b0, 1'b1, 3'd7, 8'hFF, 1'b0);
    xact(1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 1'b0);
    xact(1'b1, 1'b0, 1'b1, 3'd5, 8'hA5, 1'b0);
    xact(1'b1, 1'b1, 1'b1, 3'd7, 8'h00, 1'b0);
    // R6 deselected, both styles
    xact(1'b0, 1'b0, 1'b0, 3'd3, 8'h5A, 1'b0);
    xact(1'b1, 1'b1, 1'b0, 3'd3, 8'h5A, 1'b0);

    for (int i = 0; i < 40; i++)
      xact(1'($urandom), 1'($urandom), ($urandom % 4) != 0, 3'($urandom), 8'($urandom), 1'b0);

    do_reset(1'b1);
    // R3 directed: latch then two accesses without a new latch event
    xact(1'b0, 1'b0, 1'b1, 3'd5, 8'hC3, 1'b1);
    xact(1'b1, 1'b0, 1'b1, 3'd2, 8'h3C, 1'b0);
    xact(1'b0, 1'b1, 1'b1, 3'd1, 8'h00, 1'b0);
    xact(1'b1, 1'b1, 1'b1, 3'd6, 8'h00, 1'b1);

    for (int i = 0; i < 40; i++)
      xact(1'($urandom), 1'($urandom), ($urandom % 4) != 0, 3'($urandom), 8'($urandom), 1'($urandom));

    summary();
  end
endmodule